// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This unit carries out a 64-bit compare-and-swap on a small single-ported memory that it owns. A requester hands over a compare value, a new value, a byte base address, two register indices (compare register and base register) and two attribute bits. The unit reads the addressed doubleword and compares it with the compare value. On a match it writes the new value to the same word. On a mismatch it may write the read value back unchanged, depending on a build parameter. It reports the value read, or the original compare value if the access aborts. Each response also carries decoded acquire, release and tag-check attributes.

A second agent shares the memory through a plain access port. That port is stalled from the cycle a swap is offered until the swap has reported, so nothing can change the word between the read and the write. The agent port can mark a word as held exclusively. A swap read to that word drops the hold whether or not the compare succeeds.

The request side is valid/ready. `req_ready` is high only while the unit is idle, and a request is taken on any edge where `req_valid` and `req_ready` are both high. The request fields need only be stable in that cycle. The response is a one-cycle `rsp_valid` pulse and cannot be back-pressured, so the requester must be able to take it at any time. On the agent port, an access completes on the edge where `ag_valid` and `ag_ready` are both high.

Top module: `cas_unit`

## Requirements
- R1: `req_ready` is high and `busy` low when the unit is idle, and after reset. `req_ready` is low and `busy` high from the edge that accepts a request until the response pulse has ended.
- R2: On a match, the word at index `req_base[3 +: AW]` takes `req_new`. The response has `rsp_match`=1, `rsp_abort`=0 and `rsp_data` equal to the old word. `rsp_valid` first appears after the third clock edge counted from the accepting edge.
- R3: On a mismatch, the memory word keeps its value and the response has `rsp_match`=0 and `rsp_data` equal to the word read. With `WB_ON_FAIL`=1 (the default) the read value is written back and the response comes after the third edge. With `WB_ON_FAIL`=0 there is no write and the response comes after the second edge.
- R4: `ag_ready` is low whenever `req_valid` is high or `busy` is high. An agent access held pending during a swap completes only after the swap, so it sees the swapped word.
- R5: A base with `req_base[2:0]` not zero aborts the swap. The response has `rsp_abort`=1, `rsp_match`=0 and `rsp_data` equal to `req_cmp`, and comes after the second edge. Memory is not changed.
- R6: When `req_rn`=31 the base is treated as the stack pointer, and `req_base[3:0]` must be zero. Otherwise the swap aborts as in R5.
- R7: `rsp_acq` is 1 only when `req_l`=1 and `req_rs` is not 31.
- R8: `rsp_rel` equals `req_o0`. `rsp_tag` is 1 exactly when `req_rn` is not 31.
- R9: An agent read with `ag_excl`=1 sets `excl_held`. A non-aborted swap to that word clears it, even when the compare fails. A swap to another word, an aborted swap, or an agent write elsewhere leaves it set.
- R10: `rsp_valid` is high for exactly one cycle per accepted request, and the unit is idle in the following cycle.
- R11: The agent port reads the word at `ag_addr` combinationally into `ag_rdata`, and writes `ag_wdata` on an accepted edge with `ag_we`=1. The memory resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Swap request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_cmp | input | DW | Compare value |
| req_new | input | DW | Value stored on a match |
| req_base | input | 64 | Byte base address |
| req_rs | input | 5 | Compare-register index |
| req_rn | input | 5 | Base-register index (31 = stack pointer) |
| req_l | input | 1 | Acquire request bit |
| req_o0 | input | 1 | Release bit |
| busy | output | 1 | Swap sequence in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DW | Read value, or compare value on abort |
| rsp_match | output | 1 | Compare succeeded |
| rsp_abort | output | 1 | Access aborted on alignment |
| rsp_acq | output | 1 | Decoded acquire attribute |
| rsp_rel | output | 1 | Decoded release attribute |
| rsp_tag | output | 1 | Decoded tag-check attribute |
| ag_valid | input | 1 | Agent access offered |
| ag_ready | output | 1 | Agent access may proceed |
| ag_we | input | 1 | Agent write (1) or read (0) |
| ag_excl | input | 1 | Agent read marks the word exclusive |
| ag_addr | input | AW | Agent word index |
| ag_wdata | input | DW | Agent write data |
| ag_rdata | output | DW | Agent read data |
| excl_held | output | 1 | Exclusive hold active |

## Verification
The hardest case to reach is a contending agent access during a live swap to the same word. The ordering is only visible if the agent is held off for the whole read/write window and then lands on top of the swapped value. The stimulus raises `ag_valid` in the same cycle as `req_valid`, with a write to the swap's target. It then checks that `ag_ready` stays low on every cycle up to the response. Finally it reads the word back and expects the agent's data, while the swap itself reports the pre-swap word. The exclusive hold clearing on a failed compare gets a similar sequence: an exclusive read, a mismatching swap, then a check of `excl_held`.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } cas_state_e;

  typedef struct packed {
    logic acq;
    logic rel;
    logic tag;
  } cas_attr_t;

  localparam logic [4:0] SP_INDEX = 5'd31;
endpackage

// File: rtl/cas_attr_dec.sv
module cas_attr_dec
  import cas_pkg::*;
(
  input  logic [4:0]  rs,
  input  logic [4:0]  rn,
  input  logic        l_bit,
  input  logic        o0_bit,
  input  logic [63:0] base,
  output cas_attr_t   attr,
  output logic        misalign
);
  logic sp_base;

  always_comb begin
    sp_base   = (rn == SP_INDEX);
    attr.acq  = l_bit && (rs != SP_INDEX);
    attr.rel  = o0_bit;
    attr.tag  = !sp_base;
    // stack-pointer base needs 16-byte alignment, others 8-byte
    misalign  = sp_base ? (base[3:0] != 4'd0) : (base[2:0] != 3'd0);
  end
endmodule

// File: rtl/cas_store.sv
module cas_store #(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          mon_set,
  input  logic          mon_clr,
  input  logic [AW-1:0] mon_addr,
  output logic          excl_held
);
  logic [DW-1:0] words [DEPTH];
  logic [AW-1:0] held_addr;
  logic          held_q;

  assign rd_data   = words[rd_addr];
  assign excl_held = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      held_addr <= '0;
    end else if (mon_set) begin
      held_q    <= 1'b1;
      held_addr <= mon_addr;
    end else if (held_q && mon_addr == held_addr && (mon_clr || wr_en)) begin
      held_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
#(
  parameter int DW         = 64,
  parameter int AW         = 4,
  parameter bit WB_ON_FAIL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] cmp_in,
  input  logic [DW-1:0] new_in,
  input  logic [AW-1:0] idx_in,
  input  logic          bad_in,
  input  cas_attr_t     attr_in,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          mon_clr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_match,
  output logic          rsp_abort,
  output cas_attr_t     rsp_attr
);
  cas_state_e    state;
  logic [DW-1:0] cmp_q, new_q, rd_q, wr_q;
  logic [AW-1:0] idx_q;
  logic          bad_q, match_q;
  cas_attr_t     attr_q;
  logic          hit;

  assign hit       = (rd_data == cmp_q);
  assign busy      = (state != ST_IDLE);
  assign mem_addr  = idx_q;
  assign wr_en     = (state == ST_WR);
  assign wr_data   = wr_q;
  assign mon_clr   = (state == ST_RD) && !bad_q;
  assign rsp_valid = (state == ST_FIN);
  assign rsp_data  = bad_q ? cmp_q : rd_q;
  assign rsp_match = match_q;
  assign rsp_abort = bad_q;
  assign rsp_attr  = attr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmp_q   <= '0;
      new_q   <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      idx_q   <= '0;
      bad_q   <= 1'b0;
      match_q <= 1'b0;
      attr_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cmp_q   <= cmp_in;
          new_q   <= new_in;
          idx_q   <= idx_in;
          bad_q   <= bad_in;
          attr_q  <= attr_in;
          match_q <= 1'b0;
          state   <= ST_RD;
        end
        ST_RD: begin
          if (bad_q) begin
            state <= ST_FIN;
          end else begin
            rd_q    <= rd_data;
            match_q <= hit;
            wr_q    <= hit ? new_q : rd_data;
            state   <= (hit || WB_ON_FAIL) ? ST_WR : ST_FIN;
          end
        end
        ST_WR:   state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int DW         = 64,
  parameter int DEPTH      = 16,
  parameter bit WB_ON_FAIL = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int BYTE_SH   = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_cmp,
  input  logic [DW-1:0] req_new,
  input  logic [63:0]   req_base,
  input  logic [4:0]    req_rs,
  input  logic [4:0]    req_rn,
  input  logic          req_l,
  input  logic          req_o0,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_match,
  output logic          rsp_abort,
  output logic          rsp_acq,
  output logic          rsp_rel,
  output logic          rsp_tag,
  input  logic          ag_valid,
  output logic          ag_ready,
  input  logic          ag_we,
  input  logic          ag_excl,
  input  logic [AW-1:0] ag_addr,
  input  logic [DW-1:0] ag_wdata,
  output logic [DW-1:0] ag_rdata,
  output logic          excl_held
);
  cas_attr_t     dec_attr, out_attr;
  logic          dec_bad, start;
  logic [AW-1:0] ctl_addr, st_addr, st_waddr;
  logic          ctl_we, ctl_mclr, ag_fire, st_we, st_mset;
  logic [DW-1:0] ctl_wdata, st_rdata, st_wdata;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;
  assign ag_ready  = !busy && !req_valid;
  assign ag_fire   = ag_valid && ag_ready;

  assign st_addr   = busy ? ctl_addr : ag_addr;
  assign st_we     = ctl_we || (ag_fire && ag_we);
  assign st_waddr  = busy ? ctl_addr : ag_addr;
  assign st_wdata  = busy ? ctl_wdata : ag_wdata;
  assign st_mset   = ag_fire && !ag_we && ag_excl;
  assign ag_rdata  = st_rdata;

  assign rsp_acq = out_attr.acq;
  assign rsp_rel = out_attr.rel;
  assign rsp_tag = out_attr.tag;

  cas_attr_dec u_dec (
    .rs(req_rs), .rn(req_rn), .l_bit(req_l), .o0_bit(req_o0),
    .base(req_base), .attr(dec_attr), .misalign(dec_bad)
  );

  cas_ctrl #(.DW(DW), .AW(AW), .WB_ON_FAIL(WB_ON_FAIL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmp_in(req_cmp), .new_in(req_new),
    .idx_in(req_base[BYTE_SH +: AW]), .bad_in(dec_bad), .attr_in(dec_attr),
    .rd_data(st_rdata), .busy(busy), .mem_addr(ctl_addr),
    .wr_en(ctl_we), .wr_data(ctl_wdata), .mon_clr(ctl_mclr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_match(rsp_match),
    .rsp_abort(rsp_abort), .rsp_attr(out_attr)
  );

  cas_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(st_addr), .rd_data(st_rdata),
    .wr_en(st_we), .wr_addr(st_waddr), .wr_data(st_wdata),
    .mon_set(st_mset), .mon_clr(ctl_mclr), .mon_addr(st_addr),
    .excl_held(excl_held)
  );
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [DW-1:0] req_cmp,
  input logic [63:0]   req_base,
  input logic [4:0]    req_rs,
  input logic          req_l,
  input logic          busy,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_abort,
  input logic          rsp_acq,
  input logic          ag_ready
);
  logic l_q, rs31_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q    <= 1'b0;
      rs31_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      l_q    <= req_l;
      rs31_q <= (req_rs == 5'd31);
    end
  end

  // R4
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || req_valid) |-> !ag_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));

  // R5
  abort_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_base[2:0] != 3'd0) |=> ##1
      (rsp_valid && rsp_abort && rsp_data == $past(req_cmp, 2)));

  // R7
  acq_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_acq == (l_q && !rs31_q)));

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
endmodule

bind cas_unit cas_unit_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmp(req_cmp), .req_base(req_base), .req_rs(req_rs), .req_l(req_l),
  .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_abort(rsp_abort), .rsp_acq(rsp_acq), .ag_ready(ag_ready)
);

// File: tb/test_cas_unit.sv
module test_cas_unit;
  localparam int DW = 64;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_l = 1'b0, req_o0 = 1'b0;
  logic [DW-1:0] req_cmp = '0, req_new = '0;
  logic [63:0] req_base = '0;
  logic [4:0] req_rs = '0, req_rn = '0;
  logic req_ready, busy, rsp_valid, rsp_match, rsp_abort, rsp_acq, rsp_rel, rsp_tag;
  logic [DW-1:0] rsp_data;
  logic ag_valid = 1'b0, ag_we = 1'b0, ag_excl = 1'b0;
  logic [AW-1:0] ag_addr = '0;
  logic [DW-1:0] ag_wdata = '0;
  logic ag_ready, excl_held;
  logic [DW-1:0] ag_rdata;

  int n_chk = 0, n_bad = 0;
  int lat;
  logic [DW-1:0] r_data, rd_v;
  logic r_match, r_abort, r_acq, r_rel, r_tag;

  always #4 clk = ~clk;

  cas_unit i_cas_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ag_op(input logic we, input logic ex, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    @(negedge clk);
    ag_valid = 1'b1; ag_we = we; ag_excl = ex; ag_addr = a; ag_wdata = wd;
    #1;
    while (!ag_ready) begin @(negedge clk); #1; end
    rd = ag_rdata;
    @(posedge clk);
    @(negedge clk);
    ag_valid = 1'b0; ag_we = 1'b0; ag_excl = 1'b0;
  endtask

  task automatic cas(input logic [DW-1:0] c, input logic [DW-1:0] nv, input logic [63:0] b,
                     input logic [4:0] rs, input logic [4:0] rn, input logic l, input logic o0);
    @(negedge clk);
    req_valid = 1'b1; req_cmp = c; req_new = nv; req_base = b;
    req_rs = rs; req_rn = rn; req_l = l; req_o0 = o0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 10) begin @(negedge clk); lat++; end
    r_data = rsp_data; r_match = rsp_match; r_abort = rsp_abort;
    r_acq = rsp_acq; r_rel = rsp_rel; r_tag = rsp_tag;
    @(negedge clk);
    chk(!rsp_valid && !busy, "R10 pulse", {63'd0, rsp_valid}, 0);
  endtask

  task automatic t_reset();
    chk(req_ready && !busy, "R1 reset ready", {62'd0, req_ready, busy}, 64'd2);
    chk(!rsp_valid && !excl_held, "R1 reset outputs", {62'd0, rsp_valid, excl_held}, 0);
    ag_op(1'b0, 1'b0, 4'd5, '0, rd_v);
    chk(rd_v == 0, "R11 reset memory", rd_v, 0);
  endtask

  task automatic t_swap_hit();
    ag_op(1'b1, 1'b0, 4'd2, 64'hAAAA_0000_1111_2222, rd_v);
    cas(64'hAAAA_0000_1111_2222, 64'h5555_6666_7777_8888, 64'h10, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(r_match && !r_abort, "R2 match flag", {62'd0, r_match, r_abort}, 64'd2);
    chk(r_data == 64'hAAAA_0000_1111_2222, "R2 old value", r_data, 64'hAAAA_0000_1111_2222);
    chk(lat == 3, "R2 latency", lat, 3);
    ag_op(1'b0, 1'b0, 4'd2, '0, rd_v);
    chk(rd_v == 64'h5555_6666_7777_8888, "R2 memory swapped", rd_v, 64'h5555_6666_7777_8888);
    // upper address bits do not select the word
    cas(64'h5555_6666_7777_8888, 64'h1, 64'hF000_0000_0000_0010, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(r_match, "R2 upper base bits ignored", {63'd0, r_match}, 1);
  endtask

  task automatic t_swap_miss();
    ag_op(1'b1, 1'b0, 4'd3, 64'h0123_4567_89AB_CDEF, rd_v);
    cas(64'h0, 64'hDEAD, 64'h18, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(!r_match && !r_abort, "R3 miss flag", {62'd0, r_match, r_abort}, 0);
    chk(r_data == 64'h0123_4567_89AB_CDEF, "R3 read value", r_data, 64'h0123_4567_89AB_CDEF);
    chk(lat == 3, "R3 write-back latency", lat, 3);
    ag_op(1'b0, 1'b0, 4'd3, '0, rd_v);
    chk(rd_v == 64'h0123_4567_89AB_CDEF, "R3 memory unchanged", rd_v, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_misalign();
    ag_op(1'b1, 1'b0, 4'd4, 64'h77, rd_v);
    cas(64'h77, 64'h99, 64'h24, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(r_abort && !r_match, "R5 abort flag", {62'd0, r_abort, r_match}, 64'd2);
    chk(r_data == 64'h77, "R5 result is compare", r_data, 64'h77);
    chk(lat == 2, "R5 latency", lat, 2);
    cas(64'h1234, 64'h99, 64'h21, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(r_data == 64'h1234, "R5 result is compare 2", r_data, 64'h1234);
    ag_op(1'b0, 1'b0, 4'd4, '0, rd_v);
    chk(rd_v == 64'h77, "R5 memory untouched", rd_v, 64'h77);
  endtask

  task automatic t_sp_base();
    ag_op(1'b1, 1'b0, 4'd5, 64'h50, rd_v);
    cas(64'h50, 64'h51, 64'h28, 5'd1, 5'd31, 1'b0, 1'b0);
    chk(r_abort, "R6 sp 8-aligned aborts", {63'd0, r_abort}, 1);
    chk(r_data == 64'h50 && !r_tag, "R6 sp abort result", r_data, 64'h50);
    ag_op(1'b1, 1'b0, 4'd6, 64'h60, rd_v);
    cas(64'h60, 64'h61, 64'h30, 5'd1, 5'd31, 1'b0, 1'b0);
    chk(!r_abort && r_match, "R6 sp 16-aligned swaps", {62'd0, r_abort, r_match}, 1);
  endtask

  task automatic t_attrs();
    cas(64'h0, 64'h0, 64'h40, 5'd3, 5'd4, 1'b1, 1'b1);
    chk(r_acq, "R7 acq with L and rs!=31", {63'd0, r_acq}, 1);
    chk(r_rel && r_tag, "R8 rel and tag set", {62'd0, r_rel, r_tag}, 64'd3);
    cas(64'h0, 64'h0, 64'h40, 5'd31, 5'd4, 1'b1, 1'b0);
    chk(!r_acq, "R7 acq off for rs=31", {63'd0, r_acq}, 0);
    chk(!r_rel, "R8 rel follows o0", {63'd0, r_rel}, 0);
    cas(64'h0, 64'h0, 64'h40, 5'd3, 5'd4, 1'b0, 1'b0);
    chk(!r_acq, "R7 acq off without L", {63'd0, r_acq}, 0);
  endtask

  task automatic t_monitor();
    ag_op(1'b1, 1'b0, 4'd9, 64'h900, rd_v);
    ag_op(1'b0, 1'b1, 4'd9, '0, rd_v);
    chk(excl_held, "R9 exclusive read sets", {63'd0, excl_held}, 1);
    cas(64'h0, 64'h1, 64'h50, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(excl_held, "R9 other word keeps", {63'd0, excl_held}, 1);
    cas(64'h0, 64'h1, 64'h4C, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(excl_held, "R9 abort keeps", {63'd0, excl_held}, 1);
    cas(64'hFFFF, 64'h1, 64'h48, 5'd1, 5'd2, 1'b0, 1'b0);
    chk(!r_match && !excl_held, "R9 failed compare clears", {62'd0, r_match, excl_held}, 0);
  endtask

  task automatic t_lockout();
    int guard;
    bit held_off;
    ag_op(1'b1, 1'b0, 4'd7, 64'hC0, rd_v);
    @(negedge clk);
    req_valid = 1'b1; req_cmp = 64'hC0; req_new = 64'hC1; req_base = 64'h38;
    req_rs = 5'd1; req_rn = 5'd2; req_l = 1'b0; req_o0 = 1'b0;
    ag_valid = 1'b1; ag_we = 1'b1; ag_addr = 4'd7; ag_wdata = 64'hEE;
    #1;
    chk(!ag_ready && req_ready, "R4 agent stalled by request", {62'd0, ag_ready, req_ready}, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    held_off = 1'b1;
    guard = 0;
    while (!rsp_valid && guard < 10) begin
      if (ag_ready || !busy || req_ready) held_off = 1'b0;
      @(negedge clk); guard++;
    end
    r_data = rsp_data;
    if (ag_ready) held_off = 1'b0;
    chk(held_off, "R4 agent held during swap", {63'd0, held_off}, 1);
    chk(r_data == 64'hC0, "R4 swap saw pre-agent word", r_data, 64'hC0);
    @(negedge clk);
    #1;
    chk(ag_ready, "R4 agent released", {63'd0, ag_ready}, 1);
    @(posedge clk);
    @(negedge clk);
    ag_valid = 1'b0; ag_we = 1'b0;
    ag_op(1'b0, 1'b0, 4'd7, '0, rd_v);
    chk(rd_v == 64'hEE, "R4 agent write after swap", rd_v, 64'hEE);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_swap_hit();
    t_swap_miss();
    t_misalign();
    t_sp_base();
    t_attrs();
    t_monitor();
    t_lockout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule